// File: doc/BRIEF.md
# HDLC Frame Receiver with Validation

This block takes a serial bit stream, one bit per cycle in which `bit_valid_i` is high. It searches every bit position for the flag pattern to find where frames start and end. Inside a frame it deletes the zeros that a transmitter stuffs after runs of five ones. It runs a CRC-CCITT check over every destuffed bit, and it sorts each frame by its destuffed length and by its ending as good, short, bad or aborted. The result is a byte stream with a last-byte marker and a bad-packet tag, ready to be written into a receive FIFO. The two FCS bytes never appear on the output.

The receiver keeps the three most recent complete bytes of a frame in a small holdback store. A byte leaves the store only when a fourth byte arrives behind it, or when the frame ends. When the frame ends, the oldest held byte is the last data byte. It goes out with the last marker, and the two FCS bytes behind it are dropped. Bits are taken least significant bit first, so the first bit received becomes bit 0 of the first byte.

Top module: `hdlc_rx_validate`

## Requirements
- R1: Before the first flag is seen, and after an abort until the next flag, the receiver is hunting. Input bits then produce no output. A flag is the raw sequence 0,1,1,1,1,1,1,0 and is recognised at any bit position.
- R2: Inside a frame, a 0 bit that follows exactly five consecutive raw 1s is deleted. A deleted zero is not data, does not enter the CRC and does not count toward frame length.
- R3: A frame passes when all of these hold: it has at least 32 destuffed bits between its flags, its length is a multiple of 8, and the CRC residue is 0xF0B8. The CRC register starts at 0xFFFF and shifts one bit at a time with the reflected polynomial 0x8408 over all destuffed bits, FCS included. Every byte except the final two is then output in order, least significant bit first. The last output byte has `byte_last_o`=1 and `byte_bad_o`=0.
- R4: A frame of at least 32 destuffed bits that fails the residue check or is not a multiple of 8 outputs the same bytes as R3. The number of complete bytes is the length divided by 8, rounded down. The last output byte carries `byte_last_o`=1 and `byte_bad_o`=1. `byte_bad_o` is never 1 without `byte_last_o`.
- R5: A frame with fewer than 25 destuffed bits between its flags produces no output at all.
- R6: A frame of 25 to 31 destuffed bits outputs only its first byte, with `byte_last_o`=1 and `byte_bad_o`=1.
- R7: Seven consecutive raw 1s inside a frame abort it, and the receiver returns to hunting. Let L be the number of destuffed bits that came before the last seven destuffed bits. If L is below 25, nothing is output. Otherwise the bytes are output as in R4, with a frame length of L, and the final byte always carries `byte_bad_o`=1.
- R8: Trailing 1s at the end of the last data bits count toward the seven 1s of an abort. For example, data ending in 0,1,1,1 followed by four more raw 1s aborts on the fourth of those 1s.
- R9: The final 0 of a closing flag may also serve as the first 0 of the next opening flag. Consecutive flags, with or without a shared zero, produce no output.
- R10: Each output byte appears with `byte_valid_o` high for one cycle, in the cycle after the input bit that completes it (or ends the frame) is sampled. `byte_last_o` and `byte_bad_o` are 0 whenever `byte_valid_o` is 0, including during reset.
- R11: A cycle with `bit_valid_i` low changes no state. Any number of idle cycles between bits leaves the output sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_i | input | 1 | Serial data bit |
| bit_valid_i | input | 1 | bit_i is sampled in this cycle |
| byte_o | output | 8 | Output data byte, first received bit in bit 0 |
| byte_valid_o | output | 1 | byte_o is valid (one-cycle pulse) |
| byte_last_o | output | 1 | Final byte of a packet |
| byte_bad_o | output | 1 | Packet is invalid (only together with byte_last_o) |

## Verification
The hardest case to reach from the ports is an abort whose seven 1s begin inside the data. This needs data that ends in a run of 1s without triggering a stuffed zero. The stimulus closes the frame with a byte whose last three bits are 1s and then sends four unstuffed 1s. The bench then checks that the bad last byte appears right after the fourth 1. Length edges are reached by sweeping raw destuffed bit counts from 0 to 40 between flags. Shared-zero flags are driven by sending the seven-bit tail of a flag directly after a closing flag.

// File: rtl/hdlc_rx_pkg.sv
`timescale 1ns/1ps
package hdlc_rx_pkg;
  localparam logic [7:0]  FLAG_PAT      = 8'h7E;
  localparam int unsigned RUN_W         = 3;
  localparam int unsigned WIN_LEN       = 7;   // flag bits pushed before it is recognised
  localparam int unsigned CRC_W         = 16;
  localparam logic [15:0] CRC_INIT      = 16'hFFFF;
  localparam logic [15:0] CRC_POLY      = 16'h8408;
  localparam logic [15:0] CRC_GOOD      = 16'hF0B8;
  localparam int unsigned MIN_KEEP_BITS = 25;
  localparam int unsigned MIN_GOOD_BITS = 32;
  localparam int unsigned HOLD_BYTES    = 3;
endpackage

// File: rtl/hdlc_rx_line.sv
`timescale 1ns/1ps
module hdlc_rx_line import hdlc_rx_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  input  logic in_frame_i,
  output logic flag_o,
  output logic abort_o,
  output logic drop_o
);
  logic [6:0]       sh_q;
  logic [RUN_W-1:0] run_q;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  assign flag_o  = en_i & ({sh_q, bit_i} == FLAG_PAT);
  assign abort_o = en_i & in_frame_i & bit_i & (run_q == RUN_W'(6));
  assign drop_o  = en_i & in_frame_i & ~bit_i & (run_q == RUN_W'(5));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      run_q <= '0;
    end else if (en_i) begin
      sh_q  <= {sh_q[5:0], bit_i};
      if (!bit_i)               run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_rx_delay.sv
`timescale 1ns/1ps
module hdlc_rx_delay #(
  parameter int unsigned DEPTH = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic push_i,
  input  logic bit_i,
  output logic commit_o,
  output logic commit_bit_o
);
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic [DEPTH-1:0] dly_q;
  logic [LVL_W-1:0] lvl_q;

  assign commit_o     = push_i & (lvl_q == FULL);
  assign commit_bit_o = dly_q[DEPTH-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
      lvl_q <= '0;
    end else if (clr_i) begin
      lvl_q <= '0;
    end else if (push_i) begin
      dly_q <= {dly_q[DEPTH-2:0], bit_i};
      if (lvl_q != FULL) lvl_q <= lvl_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_rx_crc.sv
`timescale 1ns/1ps
module hdlc_rx_crc #(
  parameter int unsigned     W    = 16,
  parameter logic [W-1:0]    POLY = 16'h8408,
  parameter logic [W-1:0]    INIT = 16'hFFFF,
  parameter logic [W-1:0]    GOOD = 16'hF0B8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic step_i,
  input  logic bit_i,
  output logic ok_o
);
  logic [W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = {1'b0, crc_q[W-1:1]};
    if (crc_q[0] ^ bit_i) crc_d = crc_d ^ POLY;
  end

  assign ok_o = (crc_q == GOOD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= INIT;
    else if (init_i) crc_q <= INIT;
    else if (step_i) crc_q <= crc_d;
  end
endmodule

// File: rtl/hdlc_rx_validate.sv
`timescale 1ns/1ps
module hdlc_rx_validate import hdlc_rx_pkg::*; #(
  parameter int unsigned LEN_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       bit_valid_i,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  output logic       byte_last_o,
  output logic       byte_bad_o
);
  localparam int unsigned      HC_W     = $clog2(HOLD_BYTES + 1);
  localparam logic [LEN_W-1:0] LEN_MAX  = '1;
  localparam logic [LEN_W-1:0] KEEP_LEN = LEN_W'(MIN_KEEP_BITS);
  localparam logic [LEN_W-1:0] GOOD_LEN = LEN_W'(MIN_GOOD_BITS);
  localparam logic [HC_W-1:0]  HC_FULL  = HC_W'(HOLD_BYTES);

  logic             in_frame_q;
  logic             line_flag, line_abort, line_drop;
  logic             push, clr, commit, commit_bit, crc_ok;
  logic [LEN_W-1:0] len_q;
  logic [2:0]       idx_q;
  logic [7:0]       sr_q;
  logic [7:0]       hold_q [HOLD_BYTES];
  logic [HC_W-1:0]  hcnt_q;
  logic             byte_done, emit_mid, emit_end, end_bad;
  logic [7:0]       new_byte;

  hdlc_rx_line u_line (
    .clk_i, .rst_ni,
    .en_i       (bit_valid_i),
    .bit_i,
    .in_frame_i (in_frame_q),
    .flag_o     (line_flag),
    .abort_o    (line_abort),
    .drop_o     (line_drop)
  );

  assign push = bit_valid_i & in_frame_q & ~line_flag & ~line_abort & ~line_drop;
  assign clr  = line_flag | line_abort;

  // flag bits enter the window before the flag is seen; window is flushed on clr
  hdlc_rx_delay #(.DEPTH(WIN_LEN)) u_win (
    .clk_i, .rst_ni,
    .clr_i        (clr),
    .push_i       (push),
    .bit_i,
    .commit_o     (commit),
    .commit_bit_o (commit_bit)
  );

  hdlc_rx_crc #(
    .W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT), .GOOD(CRC_GOOD)
  ) u_crc (
    .clk_i, .rst_ni,
    .init_i (clr),
    .step_i (commit),
    .bit_i  (commit_bit),
    .ok_o   (crc_ok)
  );

  assign byte_done = commit & (idx_q == 3'd7);
  assign new_byte  = {commit_bit, sr_q[7:1]};
  assign emit_mid  = byte_done & (hcnt_q == HC_FULL);
  assign emit_end  = in_frame_q & clr & (len_q >= KEEP_LEN);
  assign end_bad   = line_abort | (len_q < GOOD_LEN) | (len_q[2:0] != 3'd0) | ~crc_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         in_frame_q <= 1'b0;
    else if (line_flag)  in_frame_q <= 1'b1;
    else if (line_abort) in_frame_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      idx_q  <= '0;
      sr_q   <= '0;
      hcnt_q <= '0;
      for (int i = 0; i < HOLD_BYTES; i++) hold_q[i] <= '0;
    end else if (clr) begin
      len_q  <= '0;
      idx_q  <= '0;
      hcnt_q <= '0;
    end else if (commit) begin
      if (len_q != LEN_MAX) len_q <= len_q + 1'b1;
      idx_q <= idx_q + 1'b1;
      sr_q  <= {commit_bit, sr_q[7:1]};
      if (byte_done) begin
        if (hcnt_q == HC_FULL) begin
          for (int i = 0; i < HOLD_BYTES - 1; i++) hold_q[i] <= hold_q[i+1];
          hold_q[HOLD_BYTES-1] <= new_byte;
        end else begin
          for (int i = 0; i < HOLD_BYTES; i++)
            if (hcnt_q == HC_W'(i)) hold_q[i] <= new_byte;
          hcnt_q <= hcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
      byte_last_o  <= 1'b0;
      byte_bad_o   <= 1'b0;
    end else begin
      byte_valid_o <= emit_mid | emit_end;
      byte_last_o  <= emit_end;
      byte_bad_o   <= emit_end & end_bad;
      if (emit_mid | emit_end) byte_o <= hold_q[0];
    end
  end
endmodule

// File: rtl/hdlc_rx_checker.sv
`timescale 1ns/1ps
module hdlc_rx_checker import hdlc_rx_pkg::*; #(
  parameter int unsigned LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_valid_i,
  input logic             in_frame_i,
  input logic [LEN_W-1:0] len_i,
  input logic             flag_i,
  input logic             drop_i,
  input logic             byte_valid_i,
  input logic             byte_last_i,
  input logic             byte_bad_i
);
  AST_QUIET_TAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |-> !(byte_last_i || byte_bad_i)); // R10
  AST_LAST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && byte_last_i) |=> !byte_valid_i); // R10
  AST_BAD_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && byte_bad_i) |-> byte_last_i); // R4
  AST_OUT_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i |-> $past(bit_valid_i)); // R11
  AST_HUNT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i |-> $past(in_frame_i)); // R1
  AST_SHORT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i |-> ($past(len_i) >= LEN_W'(MIN_KEEP_BITS))); // R5
  AST_FLAG_NOT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_i && drop_i)); // R2
endmodule

bind hdlc_rx_validate hdlc_rx_checker #(.LEN_W(LEN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_valid_i  (bit_valid_i),
  .in_frame_i   (in_frame_q),
  .len_i        (len_q),
  .flag_i       (line_flag),
  .drop_i       (line_drop),
  .byte_valid_i (byte_valid_o),
  .byte_last_i  (byte_last_o),
  .byte_bad_i   (byte_bad_o)
);

// File: tb/hdlc_rx_validate_bench.sv
`timescale 1ns/1ps
module hdlc_rx_validate_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_in, bit_vld;
  logic [7:0] byte_o;
  logic       byte_valid_o, byte_last_o, byte_bad_o;

  hdlc_rx_validate u_hdlc_rx_validate (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bit_i        (bit_in),
    .bit_valid_i  (bit_vld),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .byte_last_o  (byte_last_o),
    .byte_bad_o   (byte_bad_o)
  );

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] got_d [256];
  logic [1:0] got_t [256];
  int         got_n = 0;
  logic [7:0] exp_d [256];
  logic [1:0] exp_t [256];
  int         exp_n = 0;

  logic       fb [2048];
  int         fn = 0;
  logic [15:0] lf = 16'hACE1;
  int         tx_ones = 0;
  bit         gap_mode = 0;
  int         gap_ctr = 0;

  always @(negedge clk) begin
    if (rst_n && byte_valid_o && got_n < 256) begin
      got_d[got_n] = byte_o;
      got_t[got_n] = {byte_last_o, byte_bad_o};
      got_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic drive(input logic b);
    if (gap_mode) begin
      gap_ctr++;
      if (gap_ctr % 3 == 0) begin
        bit_vld = 1'b0;
        repeat (1 + gap_ctr % 2) @(negedge clk);
      end
    end
    bit_in  = b;
    bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic send_data_bit(input logic b);
    drive(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin
        drive(1'b0);
        tx_ones = 0;
      end
    end else tx_ones = 0;
  endtask

  task automatic send_flag_tail();
    for (int i = 0; i < 6; i++) drive(1'b1);
    drive(1'b0);
    tx_ones = 0;
  endtask

  task automatic send_flag();
    drive(1'b0);
    send_flag_tail();
  endtask

  task automatic send_body();
    for (int i = 0; i < fn; i++) send_data_bit(fb[i]);
  endtask

  task automatic add_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      fb[fn] = v[i];
      fn++;
    end
  endtask

  task automatic gen_bits(input int n);
    for (int i = 0; i < n; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      fb[fn] = lf[0];
      fn++;
    end
  endtask

  function automatic logic [15:0] crc_bits(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      if (c[0] ^ fb[i]) c = (c >> 1) ^ 16'h8408;
      else              c = c >> 1;
    end
    return c;
  endfunction

  task automatic add_fcs();
    logic [15:0] f;
    f = ~crc_bits(fn);
    add_byte(f[7:0]);
    add_byte(f[15:8]);
  endtask

  function automatic logic [7:0] fb_byte(input int j);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = fb[8*j + i];
    return v;
  endfunction

  task automatic push_exp(input logic [7:0] d, input logic l, input logic b);
    exp_d[exp_n] = d;
    exp_t[exp_n] = {l, b};
    exp_n++;
  endtask

  // expected output of a frame (or abort) with n destuffed bits counted
  task automatic expect_end(input int n, input bit aborted);
    int k;
    bit bad;
    if (n < 25) return;
    k = n / 8;
    for (int j = 0; j <= k - 4; j++) push_exp(fb_byte(j), 1'b0, 1'b0);
    bad = aborted || !(n >= 32 && n % 8 == 0 && crc_bits(n) == 16'hF0B8);
    push_exp(fb_byte(k - 3), 1'b1, bad);
  endtask

  task automatic check_frame(input string req);
    repeat (4) @(negedge clk);
    chk(got_n == exp_n, req, "byte count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_d[i] == exp_d[i], req, "data", got_d[i], exp_d[i]);
      chk(got_t[i] == exp_t[i], req, "last/bad", got_t[i], exp_t[i]);
    end
    got_n = 0;
    exp_n = 0;
  endtask

  task automatic good_frame(input int nb, input int seed);
    fn = 0;
    for (int j = 0; j < nb; j++) begin
      if (j == 0)      add_byte(8'hFF);
      else if (j == 1) add_byte(8'h7E);
      else             add_byte(8'((seed * 29 + j * 53) ^ 8'h3C));
    end
    add_fcs();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    bit_in  = 1'b0;
    bit_vld = 1'b0;
    repeat (3) @(negedge clk);
    chk({byte_valid_o, byte_last_o, byte_bad_o} == 3'b000, "R10", "reset outputs",
        {byte_valid_o, byte_last_o, byte_bad_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: hunting ignores data and idle ones before any flag
    fn = 0;
    gen_bits(64);
    send_body();
    for (int i = 0; i < 20; i++) drive(1'b1);
    check_frame("R1");

    // R3/R2: good frames with stuffed bytes, 2..9 data bytes
    for (int nb = 2; nb <= 9; nb++) begin
      good_frame(nb, nb);
      send_flag();
      send_body();
      send_flag();
      if (nb == 2) begin
        chk(byte_valid_o && byte_last_o && !byte_bad_o, "R10", "end pulse timing",
            {byte_valid_o, byte_last_o, byte_bad_o}, 3'b110);
        @(negedge clk);
        chk(!byte_valid_o, "R10", "single pulse", byte_valid_o, 0);
      end
      expect_end(fn, 1'b0);
      check_frame("R3");
    end

    // R4: corrupted FCS bit
    good_frame(4, 11);
    fb[fn - 3] = ~fb[fn - 3];
    send_flag();
    send_body();
    send_flag();
    expect_end(fn, 1'b0);
    chk(exp_t[exp_n - 1] == 2'b11, "R4", "bench expects bad tag", exp_t[exp_n - 1], 2'b11);
    check_frame("R4");

    // R5/R6/R4: length sweep
    for (int n = 0; n <= 40; n++) begin
      fn = 0;
      gen_bits(n);
      send_flag();
      send_body();
      send_flag();
      expect_end(n, 1'b0);
      if (n < 25)      check_frame("R5");
      else if (n < 32) check_frame("R6");
      else             check_frame("R4");
    end

    // R7: abort after m data bits (transmitter abort 0 + seven 1s)
    for (int m = 16; m <= 46; m += 3) begin
      fn = 0;
      gen_bits(m);
      send_flag();
      send_body();
      drive(1'b0);
      for (int i = 0; i < 7; i++) drive(1'b1);
      expect_end(m, 1'b1);
      check_frame("R7");
    end

    // R8: data ending in 0,1,1,1 then four raw ones
    fn = 0;
    gen_bits(32);
    add_byte(8'hE0);
    send_flag();
    send_body();
    for (int i = 0; i < 4; i++) drive(1'b1);
    chk(byte_valid_o && byte_last_o && byte_bad_o, "R8", "abort on fourth one",
        {byte_valid_o, byte_last_o, byte_bad_o}, 3'b111);
    expect_end(36, 1'b1);
    check_frame("R8");

    // R9: shared zero between flags
    good_frame(3, 21);
    send_flag();
    send_body();
    send_flag();
    expect_end(fn, 1'b0);
    good_frame(5, 22);
    send_flag_tail();
    send_body();
    send_flag();
    expect_end(fn, 1'b0);
    check_frame("R9");

    // R9: back-to-back flags
    for (int i = 0; i < 6; i++) send_flag();
    for (int i = 0; i < 4; i++) send_flag_tail();
    check_frame("R9");

    // R11: idle cycles between bits
    gap_mode = 1;
    good_frame(5, 31);
    send_flag();
    send_body();
    send_flag();
    expect_end(fn, 1'b0);
    check_frame("R11");
    fn = 0;
    gen_bits(29);
    send_flag();
    send_body();
    send_flag();
    expect_end(29, 1'b0);
    check_frame("R11");
    gap_mode = 0;

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule